// File: doc/BRIEF.md
# Bridge-Strip Sent-Frame Tracker

This block keeps a running count of the frames a token-ring station has put on the ring that have not yet come back to it. A MAC in bridge-stripping mode uses it to decide whether to keep removing frames from the ring. Every frame the station sends, including the special void frame, raises the count. Every frame that arrives lowers it. A set of ring events proves that the station's own traffic has gone, and any of them returns the count to zero.

The transmit and receive state machines drive the inputs. These are single-cycle strobes, plus a few level qualifiers that are valid in the same cycle as their strobe. Two control levels, a bridge-strip enable and a ring-operational flag, gate the whole function. The block produces the count, a strip-active level, and a one-cycle request for the serializer to emit the special void frame when the station leaves its data-transmit state.

Top module: `strip_tracker`

## Requirements
- R1: After reset, `sentCount` is 0 and both `stripActive` and `voidReq` are 0.
- R2: While enabled, a cycle with `txFrameSent` or `txVoidSent` high (either or both) adds exactly 1 to `sentCount` at the next clock edge.
- R3: While enabled, a cycle with `rxFrame` high subtracts 1 from `sentCount`. When an increment and a decrement fall in the same cycle, the count does not change.
- R4: `stripActive` is 1 exactly when `sentCount` is non-zero and both `bridgeStripEn` and `ringOp` are 1.
- R5: A cycle with `rxVoidSpecial` high clears `sentCount` to 0.
- R6: A cycle with `daCheck` high, `addrRecog` = 1 and `daGroup` = 0 clears the count. With `addrRecog` = 0 or `daGroup` = 1, the count is not cleared.
- R7: A cycle with `saMatch` high clears the count only when `crcOk` = 1, `lenOk` = 1 and `errInd` = 0. Any other combination of these three leaves the count unchanged.
- R8: `rxClaim`, `rxBeacon` and `rxToken` each clear the count. A token that arrives while `txActive` = 1 is a duplicate and does not clear it.
- R9: A clear takes effect before the increment and decrement of the same cycle. Clear plus increment gives 1, and clear plus decrement gives 0.
- R10: The 8-bit count holds at 255 on increment and holds at 0 on decrement.
- R11: While enabled, a `txLeaveData` strobe makes `voidReq` 1 for exactly the following cycle.
- R12: While `ringOp` = 0 or `bridgeStripEn` = 0, the count goes to 0 at the next edge, send strobes are ignored, and `voidReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bridgeStripEn | input | 1 | Bridge-stripping mode enable |
| ringOp | input | 1 | Ring operational; 0 overrides the enable |
| txFrameSent | input | 1 | Strobe: data frame sent |
| txVoidSent | input | 1 | Strobe: special void frame sent |
| txLeaveData | input | 1 | Strobe: transmitter leaving data-transmit state |
| txActive | input | 1 | Level: station is transmitting |
| rxFrame | input | 1 | Strobe: frame received |
| rxVoidSpecial | input | 1 | Strobe: special void frame received |
| daCheck | input | 1 | Strobe: destination address evaluated |
| addrRecog | input | 1 | Qualifier: address recognized |
| daGroup | input | 1 | Qualifier: destination individual/group bit |
| saMatch | input | 1 | Strobe: source address equals own long address (non-null) |
| crcOk | input | 1 | Qualifier: frame CRC valid |
| lenOk | input | 1 | Qualifier: frame length valid |
| errInd | input | 1 | Qualifier: error indicator set |
| rxClaim | input | 1 | Strobe: claim frame received |
| rxBeacon | input | 1 | Strobe: beacon frame received |
| rxToken | input | 1 | Strobe: token received |
| sentCount | output | 8 | Outstanding sent-frame count |
| stripActive | output | 1 | Additional stripping requested |
| voidReq | output | 1 | One-cycle request to send a special void frame |

## Verification
The assertions assume that the event inputs are single-cycle strobes. They also assume that the qualifiers (`addrRecog`, `daGroup`, `crcOk`, `lenOk`, `errInd`, `txActive`) are stable in the cycle of the strobe they qualify. The bench changes every input on the falling edge and returns all strobes to 0 after each checked cycle, so each event lasts exactly one clock. It also drives each qualifier together with its strobe. Clear sources are sometimes combined with increment or decrement strobes on purpose, which exercises the ordering rule.

// File: rtl/strip_pkg.sv
package strip_pkg;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef struct packed {
    logic clr;
    logic inc;
    logic dec;
  } cnt_cmd_t;
endpackage

// File: rtl/strip_ctrl.sv
module strip_ctrl
  import strip_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     bridgeStripEn,
  input  logic     ringOp,
  input  logic     txFrameSent,
  input  logic     txVoidSent,
  input  logic     txLeaveData,
  input  logic     txActive,
  input  logic     rxFrame,
  input  logic     rxVoidSpecial,
  input  logic     daCheck,
  input  logic     addrRecog,
  input  logic     daGroup,
  input  logic     saMatch,
  input  logic     crcOk,
  input  logic     lenOk,
  input  logic     errInd,
  input  logic     rxClaim,
  input  logic     rxBeacon,
  input  logic     rxToken,
  output logic     effEn,
  output cnt_cmd_t cmd,
  output logic     voidReq
);
  logic daClear, saClear, ringClear, tokClear;

  assign effEn     = bridgeStripEn & ringOp;
  assign daClear   = daCheck & addrRecog & ~daGroup;
  assign saClear   = saMatch & crcOk & lenOk & ~errInd;
  assign tokClear  = rxToken & ~txActive;          // duplicate token excluded
  assign ringClear = rxClaim | rxBeacon | tokClear;

  always_comb begin
    cmd.clr = ~effEn | rxVoidSpecial | daClear | saClear | ringClear;
    cmd.inc = effEn & (txFrameSent | txVoidSent);
    cmd.dec = effEn & rxFrame;
  end

  always_ff @(posedge clk) begin
    if (!rstN) voidReq <= 1'b0;
    else       voidReq <= effEn & txLeaveData;
  end

  // R11: a void request follows a leave strobe issued while enabled
  p_void_follow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (effEn && txLeaveData) |=> voidReq);
  // R12: no void request when the previous cycle was disabled
  p_void_gate_r12: assert property (@(posedge clk) disable iff (!rstN)
    !effEn |=> !voidReq);
endmodule

// File: rtl/strip_dp.sv
module strip_dp
  import strip_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cnt_cmd_t         cmd,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] base, nxt;

  always_comb begin
    base = cmd.clr ? '0 : cnt;
    nxt  = base;
    if (cmd.inc && !cmd.dec && base != CNT_MAX) nxt = base + 1'b1;
    if (cmd.dec && !cmd.inc && base != '0)      nxt = base - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= nxt;
  end

  // R9: after a clear the count is at most 1
  p_clear_ceiling_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> cnt <= 1);
  // R2: plain increment below the ceiling adds one
  p_inc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.clr && cmd.inc && !cmd.dec && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
  // R3: plain decrement above zero subtracts one
  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.clr && cmd.dec && !cmd.inc && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R10: ceiling and floor hold
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.clr && cnt == CNT_MAX && cmd.inc) |=> cnt == CNT_MAX);
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && cmd.dec && !cmd.inc) |=> cnt == '0);
endmodule

// File: rtl/strip_tracker.sv
module strip_tracker
  import strip_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bridgeStripEn,
  input  logic             ringOp,
  input  logic             txFrameSent,
  input  logic             txVoidSent,
  input  logic             txLeaveData,
  input  logic             txActive,
  input  logic             rxFrame,
  input  logic             rxVoidSpecial,
  input  logic             daCheck,
  input  logic             addrRecog,
  input  logic             daGroup,
  input  logic             saMatch,
  input  logic             crcOk,
  input  logic             lenOk,
  input  logic             errInd,
  input  logic             rxClaim,
  input  logic             rxBeacon,
  input  logic             rxToken,
  output logic [CNT_W-1:0] sentCount,
  output logic             stripActive,
  output logic             voidReq
);
  cnt_cmd_t cmd;
  logic     effEn;

  strip_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bridgeStripEn(bridgeStripEn), .ringOp(ringOp),
    .txFrameSent(txFrameSent), .txVoidSent(txVoidSent), .txLeaveData(txLeaveData),
    .txActive(txActive), .rxFrame(rxFrame), .rxVoidSpecial(rxVoidSpecial),
    .daCheck(daCheck), .addrRecog(addrRecog), .daGroup(daGroup),
    .saMatch(saMatch), .crcOk(crcOk), .lenOk(lenOk), .errInd(errInd),
    .rxClaim(rxClaim), .rxBeacon(rxBeacon), .rxToken(rxToken),
    .effEn(effEn), .cmd(cmd), .voidReq(voidReq)
  );

  strip_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cnt(sentCount)
  );

  assign stripActive = effEn & (sentCount != '0);

  // R4: stripping implies a non-zero count
  p_strip_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    stripActive |-> sentCount != '0);
  // R12: dropping ring-operational empties the count
  p_ring_down_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ringOp |=> sentCount == '0);
  // R8: a non-duplicate token clears the count
  p_token_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxToken && !txActive && !txFrameSent && !txVoidSent) |=> sentCount == '0);
endmodule

// File: tb/tb_strip_tracker.sv
module tb_strip_tracker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0, ring = 1'b0;
  logic [15:0] ev = '0;
  logic [7:0] cnt;
  logic strip, vreq;
  int nChk = 0, nErr = 0;
  int model = 0;
  logic expV = 1'b0;
  bit done = 1'b0;

  // event bits: 0 txFrameSent 1 txVoidSent 2 txLeaveData 3 rxFrame 4 rxVoidSpecial
  // 5 daCheck 6 addrRecog 7 daGroup 8 saMatch 9 crcOk 10 lenOk 11 errInd
  // 12 rxClaim 13 rxBeacon 14 rxToken 15 txActive
  always #5 clk = ~clk;

  strip_tracker dut (
    .clk(clk), .rstN(rstN), .bridgeStripEn(en), .ringOp(ring),
    .txFrameSent(ev[0]), .txVoidSent(ev[1]), .txLeaveData(ev[2]), .txActive(ev[15]),
    .rxFrame(ev[3]), .rxVoidSpecial(ev[4]), .daCheck(ev[5]), .addrRecog(ev[6]),
    .daGroup(ev[7]), .saMatch(ev[8]), .crcOk(ev[9]), .lenOk(ev[10]), .errInd(ev[11]),
    .rxClaim(ev[12]), .rxBeacon(ev[13]), .rxToken(ev[14]),
    .sentCount(cnt), .stripActive(strip), .voidReq(vreq)
  );

  task automatic chk(input string tag);
    logic expS;
    expS = (model != 0) && en && ring;
    nChk++;
    if (cnt != model[7:0] || strip != expS || vreq != expV) begin
      nErr++;
      $display("FAIL %s: cnt=%0d strip=%0b vreq=%0b expected cnt=%0d strip=%0b vreq=%0b",
               tag, cnt, strip, vreq, model, expS, expV);
    end
  endtask

  task automatic step(input logic [15:0] v, input string tag);
    logic eff, clr, inc, dec;
    @(negedge clk);
    ev = v;
    eff = en & ring;
    clr = !eff | v[4] | (v[5] & v[6] & !v[7]) | (v[8] & v[9] & v[10] & !v[11])
          | v[12] | v[13] | (v[14] & !v[15]);
    inc = eff & (v[0] | v[1]);
    dec = eff & v[3];
    @(posedge clk);
    if (clr) model = 0;
    if (inc && !dec && model < 255) model++;
    if (dec && !inc && model > 0) model--;
    expV = eff & v[2];
    #1;
    chk(tag);
    ev = '0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) step(16'h0001, "R2 fill");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nErr++; nChk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; chk("R1 reset");
    @(negedge clk); rstN = 1'b1; en = 1'b1; ring = 1'b1;
    step(16'h0000, "R1 idle");
    fill(3);
    step(16'h0002, "R2 void sent");
    step(16'h0003, "R2 both sent");
    step(16'h0008, "R3 receive");
    step(16'h0009, "R3 inc and dec");
    step(16'h0000, "R4 strip on");
    step(16'h0010, "R5 special void rx");
    step(16'h0000, "R4 strip off at zero");
    // R6 sweep over recog/group
    for (int k = 0; k < 4; k++) begin
      fill(2);
      step(16'h0020 | (16'(k) << 6), "R6 DA match");
    end
    // R7 sweep over crc/len/err
    for (int k = 0; k < 8; k++) begin
      fill(2);
      step(16'h0100 | (16'(k) << 9), "R7 SA match");
    end
    fill(2); step(16'h1000, "R8 claim");
    fill(2); step(16'h2000, "R8 beacon");
    fill(2); step(16'h4000, "R8 token");
    fill(2); step(16'hC000, "R8 duplicate token");
    step(16'h4001, "R9 clear plus inc");
    fill(2); step(16'h1008, "R9 clear plus dec");
    fill(260);
    step(16'h0001, "R10 ceiling");
    for (int i = 0; i < 256; i++) step(16'h0008, "R10 drain");
    step(16'h0008, "R10 floor");
    step(16'h0004, "R11 leave data");
    step(16'h0000, "R11 pulse ends");
    fill(3);
    @(negedge clk); ring = 1'b0;
    step(16'h0005, "R12 ring down");
    step(16'h0001, "R12 send ignored");
    @(negedge clk); ring = 1'b1; en = 1'b0;
    step(16'h0005, "R12 enable off");
    @(negedge clk); en = 1'b1;
    fill(1);
    step(16'h0000, "R4 re-enabled");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end
endmodule